// File: doc/BRIEF.md
# Control-Flow Trace Buffer

This block records a stream of control-flow entries coming from a processor core into an on-chip circular store. Software later drains the store to rebuild the path the program took. Capture runs while an enable bit is set. A mode bit selects one of two behaviours when the store fills up:

- **Fill-once mode:** capture halts at full and the block raises a one-cycle debug-exception request.
- **Wrap mode:** capture keeps going and overwrites the oldest entries until software clears the enable.

Software reaches the block through a small coprocessor-style register port. A register number picks one of three registers:

- a control register (enable and mode),
- a status register (full flag and entry count),
- a data port. Each read of the data port returns the oldest entry that is still stored and removes it.

An access with an unmapped register number, or with any other selector field non-zero, returns an undefined-access error pulse instead of a response. Reads answer one cycle after the request.

Top module: `ctf_trace_buffer`

## Requirements
- R1: After reset the control register reads 0 (capture disabled, fill-once mode), the status register reads 0, and the exception and error outputs are low.
- R2: While enabled, each cycle with `tr_valid` high stores `tr_data`. The status register reports the full flag in bit 0 and the entry count (0..DEPTH) in bits [9:1] for the default DEPTH of 256.
- R3: In fill-once mode (control bit 1 = 0) the store accepts exactly DEPTH entries and drops later ones. `dbg_exc` is high for exactly one cycle, in the cycle after the edge that stores the DEPTH-th entry.
- R4: In wrap mode (control bit 1 = 1), an entry that arrives when the store is full overwrites the oldest entry. The count stays at DEPTH and `dbg_exc` is never raised.
- R5: Entries that arrive while control bit 0 (enable) is 0 are dropped.
- R6: A read of register 2 returns the oldest stored entry and decrements the count. A read of register 2 when the count is 0 returns 0 and still gives a valid response.
- R7: A control write with bit 0 = 1 while capture is already enabled empties the store and restarts capture. A control write with bit 0 = 0 stops capture and keeps the stored entries for draining.
- R8: A read of register 0 returns enable in bit 0 and mode in bit 1, with all other bits 0.
- R9: A request with a register number above 2, or with a non-zero `cp_aux`, pulses `cp_undef` in the next cycle. It gives no `cp_rvalid` and does not change the control register.
- R10: `cp_rvalid` goes high for one cycle, in the cycle after each mapped read request, and `cp_rdata` holds the read value in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tr_valid | input | 1 | Trace entry present this cycle |
| tr_data | input | DATA_W | Trace entry value |
| cp_req | input | 1 | Register access request |
| cp_wr | input | 1 | 1 = write, 0 = read |
| cp_regnum | input | 4 | Register number (0 control, 1 status, 2 data) |
| cp_aux | input | 8 | Other selector fields; must be zero |
| cp_wdata | input | DATA_W | Write data |
| cp_rdata | output | DATA_W | Read data, valid with cp_rvalid |
| cp_rvalid | output | 1 | Read response pulse |
| cp_undef | output | 1 | Undefined-access error pulse |
| dbg_exc | output | 1 | Debug-exception request pulse |

## Verification
The capture path is driven with random entry values and random idle gaps in three cases: while disabled, in fill-once mode well past full, and in wrap mode more than twice past full. Each case tells apart dropping, stopping and overwriting, because the drained sequence must match a queue model entry by entry, oldest first. The exception line is checked after every single entry, which separates a correctly timed single pulse from a late, repeated or missing one. Directed cases cover a restart during capture, a read of an empty store, and malformed selectors that must leave the control register untouched.

// File: rtl/ctf_pkg.sv
package ctf_pkg;
  localparam logic [3:0] SEL_CTRL = 4'd0;
  localparam logic [3:0] SEL_STAT = 4'd1;
  localparam logic [3:0] SEL_DATA = 4'd2;

  typedef enum logic {
    MODE_FILL = 1'b0,
    MODE_WRAP = 1'b1
  } cap_mode_e;
endpackage

// File: rtl/ctf_ram.sv
module ctf_ram #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Simple dual-port, read-first, registered read: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    q <= mem[raddr];
  end
endmodule

// File: rtl/ctf_capture.sv
module ctf_capture
  import ctf_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  cap_mode_e     mode,
  input  logic          restart,
  input  logic          tr_valid,
  input  logic          pop,
  output logic          push,
  output logic [AW-1:0] wp,
  output logic [AW-1:0] rp,
  output logic [CW-1:0] cnt,
  output logic          dbg_exc
);
  logic full, grow;

  assign full = (cnt == CW'(DEPTH));
  assign push = en && tr_valid && !restart && (!full || mode == MODE_WRAP);
  assign grow = push && !full;
  // Oldest entry sits cnt slots behind the write pointer.
  assign rp   = wp - cnt[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp      <= '0;
      cnt     <= '0;
      dbg_exc <= 1'b0;
    end else begin
      dbg_exc <= 1'b0;
      if (restart) begin
        wp  <= '0;
        cnt <= '0;
      end else begin
        if (push) wp <= wp + 1'b1;
        cnt     <= cnt + CW'(grow) - CW'(pop);
        dbg_exc <= (mode == MODE_FILL) && grow && !pop && (cnt == CW'(DEPTH - 1));
      end
    end
  end

  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  a_r3_exc_at_full: assert property (@(posedge clk) disable iff (rst)
    dbg_exc |-> full);
  a_r3_exc_single: assert property (@(posedge clk) disable iff (rst)
    dbg_exc |=> !dbg_exc);
  a_r3_full_drop: assert property (@(posedge clk) disable iff (rst)
    (en && mode == MODE_FILL && full && tr_valid && !restart) |=> $stable(wp));
  a_r4_wrap_no_exc: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_WRAP) |=> !dbg_exc);
  a_r4_wrap_overwrite: assert property (@(posedge clk) disable iff (rst)
    (en && mode == MODE_WRAP && full && tr_valid && !restart && !pop)
      |=> (full && wp != $past(wp)));
  a_r5_disabled_drop: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(wp));
endmodule

// File: rtl/ctf_regs.sv
module ctf_regs
  import ctf_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cp_req,
  input  logic              cp_wr,
  input  logic [3:0]        cp_regnum,
  input  logic [7:0]        cp_aux,
  input  logic [DATA_W-1:0] cp_wdata,
  input  logic [CW-1:0]     cnt,
  input  logic [DATA_W-1:0] ram_q,
  output logic              en,
  output cap_mode_e         mode,
  output logic              restart,
  output logic              pop,
  output logic [DATA_W-1:0] cp_rdata,
  output logic              cp_rvalid,
  output logic              cp_undef
);
  logic              sel_ok, rd_ok, ctrl_we, data_sel_q;
  logic [DATA_W-1:0] hold_q, ctrl_v, stat_v;
  logic              unused_wdata;

  assign unused_wdata = ^cp_wdata[DATA_W-1:2];
  assign sel_ok  = (cp_aux == 8'd0) && (cp_regnum <= SEL_DATA);
  assign rd_ok   = cp_req && !cp_wr && sel_ok;
  assign ctrl_we = cp_req && cp_wr && sel_ok && (cp_regnum == SEL_CTRL);
  assign restart = ctrl_we && en && cp_wdata[0];
  assign pop     = rd_ok && (cp_regnum == SEL_DATA) && (cnt != '0);

  always_comb begin
    ctrl_v    = '0;
    ctrl_v[0] = en;
    ctrl_v[1] = mode;
    stat_v    = '0;
    stat_v[0] = (cnt == CW'(DEPTH));
    stat_v[CW:1] = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en         <= 1'b0;
      mode       <= MODE_FILL;
      hold_q     <= '0;
      data_sel_q <= 1'b0;
      cp_rvalid  <= 1'b0;
      cp_undef   <= 1'b0;
    end else begin
      cp_rvalid  <= rd_ok;
      cp_undef   <= cp_req && !sel_ok;
      data_sel_q <= pop;
      if (rd_ok) begin
        case (cp_regnum)
          SEL_CTRL: hold_q <= ctrl_v;
          SEL_STAT: hold_q <= stat_v;
          default:  hold_q <= '0;
        endcase
      end
      if (ctrl_we) begin
        en   <= cp_wdata[0];
        mode <= cap_mode_e'(cp_wdata[1]);
      end
    end
  end

  // Data reads come from the RAM output register; all else from hold_q.
  assign cp_rdata = data_sel_q ? ram_q : hold_q;

  a_r9_undef_excl: assert property (@(posedge clk) disable iff (rst)
    !(cp_undef && cp_rvalid));
  a_r9_undef_keeps_ctrl: assert property (@(posedge clk) disable iff (rst)
    (cp_req && !sel_ok) |=> ($stable(en) && $stable(mode)));
  a_r10_rvalid_cause: assert property (@(posedge clk) disable iff (rst)
    cp_rvalid |-> $past(cp_req && !cp_wr));
  a_r10_rvalid_pulse: assert property (@(posedge clk) disable iff (rst)
    (cp_req && !cp_wr && sel_ok) |=> cp_rvalid);
endmodule

// File: rtl/ctf_trace_buffer.sv
module ctf_trace_buffer
  import ctf_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tr_valid,
  input  logic [DATA_W-1:0] tr_data,
  input  logic              cp_req,
  input  logic              cp_wr,
  input  logic [3:0]        cp_regnum,
  input  logic [7:0]        cp_aux,
  input  logic [DATA_W-1:0] cp_wdata,
  output logic [DATA_W-1:0] cp_rdata,
  output logic              cp_rvalid,
  output logic              cp_undef,
  output logic              dbg_exc
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic              en, restart, pop, push;
  cap_mode_e         mode;
  logic [AW-1:0]     wp, rp;
  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] ram_q;

  ctf_regs #(.DEPTH(DEPTH), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst(rst), .cp_req(cp_req), .cp_wr(cp_wr),
    .cp_regnum(cp_regnum), .cp_aux(cp_aux), .cp_wdata(cp_wdata),
    .cnt(cnt), .ram_q(ram_q), .en(en), .mode(mode), .restart(restart),
    .pop(pop), .cp_rdata(cp_rdata), .cp_rvalid(cp_rvalid), .cp_undef(cp_undef)
  );

  ctf_capture #(.DEPTH(DEPTH)) cap_i (
    .clk(clk), .rst(rst), .en(en), .mode(mode), .restart(restart),
    .tr_valid(tr_valid), .pop(pop), .push(push), .wp(wp), .rp(rp),
    .cnt(cnt), .dbg_exc(dbg_exc)
  );

  ctf_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) ram_i (
    .clk(clk), .we(push), .waddr(wp), .wdata(tr_data),
    .raddr(rp), .q(ram_q)
  );
endmodule

// File: tb/ctf_trace_buffer_tb_top.sv
`timescale 1ns/1ps
module ctf_trace_buffer_tb_top;
  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tr_valid = 1'b0;
  logic [31:0] tr_data = '0;
  logic        cp_req = 1'b0, cp_wr = 1'b0;
  logic [3:0]  cp_regnum = '0;
  logic [7:0]  cp_aux = '0;
  logic [31:0] cp_wdata = '0;
  logic [31:0] cp_rdata;
  logic        cp_rvalid, cp_undef, dbg_exc;

  int nchk = 0, nfail = 0, nexc = 0;
  bit done = 0;
  logic [31:0] mq[$];
  bit m_en = 0, m_wrap = 0;

  always #10 clk = ~clk;

  ctf_trace_buffer #(.DEPTH(DEPTH), .DATA_W(32)) dut_i (
    .clk(clk), .rst(rst), .tr_valid(tr_valid), .tr_data(tr_data),
    .cp_req(cp_req), .cp_wr(cp_wr), .cp_regnum(cp_regnum), .cp_aux(cp_aux),
    .cp_wdata(cp_wdata), .cp_rdata(cp_rdata), .cp_rvalid(cp_rvalid),
    .cp_undef(cp_undef), .dbg_exc(dbg_exc)
  );

  always @(negedge clk) if (!rst && dbg_exc) nexc++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [3:0] rn, input logic [7:0] aux,
                        input logic [31:0] wd, output logic [31:0] rd,
                        output logic rv, output logic ud);
    @(negedge clk);
    cp_req = 1'b1; cp_wr = wr; cp_regnum = rn; cp_aux = aux; cp_wdata = wd;
    @(negedge clk);
    rd = cp_rdata; rv = cp_rvalid; ud = cp_undef;
    cp_req = 1'b0; cp_wr = 1'b0; cp_aux = '0;
  endtask

  function automatic logic [31:0] exp_status();
    return (32'(mq.size()) << 1) | 32'(mq.size() == DEPTH);
  endfunction

  task automatic ctrl_write(input logic [31:0] v);
    logic [31:0] rd; logic rv, ud;
    access(1'b1, 4'd0, 8'd0, v, rd, rv, ud);
    if (m_en && v[0]) mq.delete();
    m_en = v[0]; m_wrap = v[1];
  endtask

  task automatic read_ctrl(input string req);
    logic [31:0] rd; logic rv, ud;
    access(1'b0, 4'd0, 8'd0, '0, rd, rv, ud);
    chk(req, rd, {30'd0, m_wrap, m_en});
  endtask

  task automatic read_status(input string req);
    logic [31:0] rd; logic rv, ud;
    access(1'b0, 4'd1, 8'd0, '0, rd, rv, ud);
    chk(req, rd, exp_status());
  endtask

  task automatic read_data(input string req);
    logic [31:0] rd, e; logic rv, ud;
    access(1'b0, 4'd2, 8'd0, '0, rd, rv, ud);
    e = (mq.size() == 0) ? 32'd0 : mq.pop_front();
    chk("R10 data rvalid", {31'd0, rv}, 32'd1);
    chk(req, rd, e);
  endtask

  task automatic push(input logic [31:0] d);
    bit ex = 0;
    @(negedge clk);
    tr_valid = 1'b1; tr_data = d;
    if (m_en) begin
      if (mq.size() < DEPTH) begin
        mq.push_back(d);
        ex = !m_wrap && (mq.size() == DEPTH);
      end else if (m_wrap) begin
        void'(mq.pop_front());
        mq.push_back(d);
      end
    end
    @(negedge clk);
    tr_valid = 1'b0;
    chk(m_wrap ? "R4 no exception in wrap" : "R3 exception timing",
        {31'd0, dbg_exc}, {31'd0, ex});
    if ($urandom % 4 == 0) @(negedge clk);
  endtask

  task automatic drain(input string req);
    while (mq.size() != 0) read_data(req);
  endtask

  initial begin
    logic [31:0] rd; logic rv, ud; int e0;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 exc low", {31'd0, dbg_exc}, 32'd0);
    read_ctrl("R1 ctrl reset");
    read_status("R1 status reset");

    // R5 disabled drop
    for (int i = 0; i < 5; i++) push($urandom);
    read_status("R5 disabled entries dropped");

    // R2/R3 fill-once beyond full
    ctrl_write(32'h1);
    read_ctrl("R8 ctrl fill enabled");
    for (int i = 0; i < 100; i++) push($urandom);
    read_status("R2 partial count");
    for (int i = 0; i < 200; i++) push($urandom);
    read_status("R3 full status");
    chk("R3 one exception per fill", nexc, 1);

    // R7 disable keeps data; R6 ordered drain
    ctrl_write(32'h0);
    read_status("R7 disable keeps entries");
    for (int i = 0; i < 10; i++) read_data("R6 fill-once drain order");
    read_status("R6 count after partial drain");
    drain("R6 fill-once drain order");
    read_data("R6 empty read returns 0");
    read_status("R6 status empty");

    // R4 wrap mode
    e0 = nexc;
    ctrl_write(32'h3);
    for (int i = 0; i < 600; i++) push($urandom);
    read_status("R4 wrap full status");
    chk("R4 no exception count", nexc, e0);
    ctrl_write(32'h2);
    read_ctrl("R8 ctrl wrap disabled");
    drain("R4 wrap keeps newest entries");
    read_status("R4 wrap drained");

    // R7 restart while enabled
    ctrl_write(32'h1);
    for (int i = 0; i < 10; i++) push($urandom);
    ctrl_write(32'h1);
    read_status("R7 restart clears count");
    for (int i = 0; i < 3; i++) push($urandom);
    ctrl_write(32'h0);
    drain("R7 entries after restart");

    // R9 undefined accesses
    access(1'b0, 4'd5, 8'd0, '0, rd, rv, ud);
    chk("R9 unmapped undef", {31'd0, ud}, 32'd1);
    chk("R9 unmapped no rvalid", {31'd0, rv}, 32'd0);
    access(1'b1, 4'd0, 8'h01, 32'h3, rd, rv, ud);
    chk("R9 aux nonzero undef", {31'd0, ud}, 32'd1);
    read_ctrl("R9 ctrl unchanged");
    access(1'b0, 4'd1, 8'h80, '0, rd, rv, ud);
    chk("R9 status aux undef", {31'd0, ud}, 32'd1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule